// File: doc/BRIEF.md
# Sleep Mode Controller

This block manages low-power states for a small processor core. Software sets a sleep-enable flag and a three-bit mode code. The core then raises a one-cycle sleep strobe. If the flag is set, the controller captures the mode and halts the core. It then drives a mode-specific pattern onto seven enable outputs. Five of these are clock domains: core, program memory, peripheral I/O, converter and asynchronous timer. The other two are oscillators: main and timer crystal.

While asleep, the controller accepts only the wake requests that the captured mode allows. An accepted wake starts the wake sequence. In the two modes that stop the main oscillator, the controller first waits out a start-up delay. In every mode it then holds the core halted for a fixed four-cycle window, and after that it releases the core with a one-cycle resume pulse. A reset event that arrives while the core is asleep skips this sequence. It returns the block to the running state at once and emits a restart indication instead of a resume.

Top module: `slp_ctrl`

## Requirements
- R1: After reset the core is running: all seven enables are 1, and `core_halt`, `resume` and `rst_vec` are 0.
- R2: A sleep strobe seen while `cfg_en` is 0 is ignored. The core keeps running with every enable at 1.
- R3: A sleep strobe with `cfg_en` at 1 in the running state sets `core_halt` from the next cycle. The mode codes are: 000 idle, 001 converter-quiet, 010 deep-off, 011 timer-save, 110 standby and 111 extended standby. Codes 100 and 101 behave exactly as idle.
- R4: Sleep-state enables, in the order {cpu, flash, io, adc, asy, main, tosc}, where `a` is `t2_async`:
  - idle gives 0,0,1,1,1,1,a
  - converter-quiet gives 0,0,0,1,1,1,a
  - deep-off gives all 0
  - timer-save gives 0,0,0,0,a,0,a
  - standby gives 0,0,0,0,0,1,0
  - extended standby gives 0,0,0,0,a,1,a
- R5: The `wake_req` bits are: 0 ext0, 1 ext1, 2 pin-change, 3 bus address match, 4 timer2, 5 nonvolatile-write ready, 6 converter done, 7 watchdog, 8 other I/O. The accepted sets are:
  - idle accepts all bits
  - converter-quiet accepts bits 0 to 7
  - deep-off and standby accept bits 0, 1, 2, 3 and 7
  - timer-save and extended standby accept bits 0, 1, 2, 3, 4 and 7
- R6: Outside idle, ext0 and ext1 wake the core only when the matching `int_level` bit is 1 (level-sensed).
- R7: A masked wake request leaves `core_halt` and all enables unchanged.
- R8: After the edge that samples an accepted wake, `core_halt` falls and `resume` pulses for one cycle at the HALT_CYC-th edge. In deep-off and timer-save this happens at the (STARTUP_CYC+HALT_CYC)-th edge instead. While the core is halted in the final window, all enables are 1.
- R9: `rst_wake` while asleep returns the core to running at the next edge, with `rst_vec` high for one cycle and no `resume`. In the running state, `rst_wake` has no effect.
- R10: The mode is captured at sleep entry. Later changes to `cfg_mode` do not alter the enables or the accepted wake set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Sleep-enable flag |
| cfg_mode | input | 3 | Sleep mode code |
| t2_async | input | 1 | Timer2 runs from its own crystal |
| int_level | input | 2 | ext0/ext1 configured level-sensed |
| sleep_req | input | 1 | Sleep instruction strobe |
| wake_req | input | 9 | Raw wake requests |
| rst_wake | input | 1 | Reset event from a reset source |
| clk_cpu_en | output | 1 | Core clock enable |
| clk_flash_en | output | 1 | Program memory clock enable |
| clk_io_en | output | 1 | Peripheral I/O clock enable |
| clk_adc_en | output | 1 | Converter clock enable |
| clk_asy_en | output | 1 | Asynchronous timer clock enable |
| osc_main_en | output | 1 | Main oscillator enable |
| osc_tmr_en | output | 1 | Timer crystal oscillator enable |
| core_halt | output | 1 | Core must not execute |
| resume | output | 1 | One-cycle pulse: continue after sleep |
| rst_vec | output | 1 | One-cycle pulse: restart from reset vector |

## Verification
A wrong sequencer state shows at the ports in the cycle after the edge that caused it. A missed entry leaves `core_halt` low with the clocks on. A lost count moves the `resume` edge away from its exact cycle. A leaked clock enable in a mode shows in the first sleeping cycle. A wrong wake mask shows within one edge of a single raised request: the core either wakes when it should not or keeps `core_halt` high. A mode register that follows `cfg_mode` during sleep changes the enables at the next edge.

// File: rtl/slp_pkg.sv
package slp_pkg;
  localparam int WAKE_N = 9;

  localparam logic [2:0] MD_IDLE  = 3'b000;
  localparam logic [2:0] MD_ADCQ  = 3'b001;
  localparam logic [2:0] MD_DOFF  = 3'b010;
  localparam logic [2:0] MD_TSAVE = 3'b011;
  localparam logic [2:0] MD_STBY  = 3'b110;
  localparam logic [2:0] MD_XSTBY = 3'b111;

  // wake request bit positions
  localparam int WK_EXT0 = 0;
  localparam int WK_EXT1 = 1;
  localparam int WK_PCH  = 2;
  localparam int WK_ADDR = 3;
  localparam int WK_TMR2 = 4;
  localparam int WK_NVM  = 5;
  localparam int WK_CONV = 6;
  localparam int WK_WDOG = 7;
  localparam int WK_IO   = 8;

  typedef struct packed {
    logic cpu;
    logic flash;
    logic io;
    logic adc;
    logic asy;
    logic main;
    logic tosc;
  } clk_en_t;

  localparam clk_en_t CLK_ALL_ON = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_START = 2'd2,
    ST_HALT  = 2'd3
  } seq_st_e;
endpackage

// File: rtl/slp_mode_lut.sv
module slp_mode_lut
  import slp_pkg::*;
(
  input  logic [2:0]        mode,
  input  logic              t2_async,
  output clk_en_t           clk_sleep,
  output logic [WAKE_N-1:0] wake_mask,
  output logic              need_start,
  output logic              idle_like
);
  localparam logic [WAKE_N-1:0] WM_PINS = (WAKE_N'(1) << WK_EXT0) | (WAKE_N'(1) << WK_EXT1) |
                                          (WAKE_N'(1) << WK_PCH);
  localparam logic [WAKE_N-1:0] WM_BASE = WM_PINS | (WAKE_N'(1) << WK_ADDR) | (WAKE_N'(1) << WK_WDOG);
  localparam logic [WAKE_N-1:0] WM_TMR  = WM_BASE | (WAKE_N'(1) << WK_TMR2);
  localparam logic [WAKE_N-1:0] WM_CONV = WM_TMR | (WAKE_N'(1) << WK_NVM) | (WAKE_N'(1) << WK_CONV);

  always_comb begin
    clk_sleep  = '0;
    wake_mask  = '1;
    need_start = 1'b0;
    idle_like  = 1'b0;
    case (mode)
      MD_ADCQ: begin
        clk_sleep.adc  = 1'b1;
        clk_sleep.asy  = 1'b1;
        clk_sleep.main = 1'b1;
        clk_sleep.tosc = t2_async;
        wake_mask      = WM_CONV;
      end
      MD_DOFF: begin
        wake_mask  = WM_BASE;
        need_start = 1'b1;
      end
      MD_TSAVE: begin
        clk_sleep.asy  = t2_async;
        clk_sleep.tosc = t2_async;
        wake_mask      = WM_TMR;
        need_start     = 1'b1;
      end
      MD_STBY: begin
        clk_sleep.main = 1'b1;
        wake_mask      = WM_BASE;
      end
      MD_XSTBY: begin
        clk_sleep.asy  = t2_async;
        clk_sleep.main = 1'b1;
        clk_sleep.tosc = t2_async;
        wake_mask      = WM_TMR;
      end
      default: begin // idle and the two spare codes
        clk_sleep.io   = 1'b1;
        clk_sleep.adc  = 1'b1;
        clk_sleep.asy  = 1'b1;
        clk_sleep.main = 1'b1;
        clk_sleep.tosc = t2_async;
        idle_like      = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/slp_wake_filter.sv
module slp_wake_filter
  import slp_pkg::*;
#(
  parameter int EXT_N = 2
) (
  input  logic [WAKE_N-1:0] wake_req,
  input  logic [WAKE_N-1:0] wake_mask,
  input  logic [EXT_N-1:0]  int_level,
  input  logic              idle_like,
  output logic              wake_hit
);
  logic [WAKE_N-1:0] eff_mask;

  for (genvar i = 0; i < WAKE_N; i++) begin : g_bit
    if (i < EXT_N) begin : g_ext
      // edge-sensed external pins only wake from idle
      assign eff_mask[i] = wake_mask[i] & (idle_like | int_level[i]);
    end else begin : g_std
      assign eff_mask[i] = wake_mask[i];
    end
  end

  assign wake_hit = |(wake_req & eff_mask);
endmodule

// File: rtl/slp_seq.sv
module slp_seq
  import slp_pkg::*;
#(
  parameter int STARTUP_CYC = 16,
  parameter int HALT_CYC    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_go,
  input  logic [2:0] mode_in,
  input  logic       wake_hit,
  input  logic       need_start,
  input  logic       rst_wake,
  output seq_st_e    st,
  output logic [2:0] mode_q,
  output logic       resume,
  output logic       rst_vec
);
  localparam int CNT_MAX = (STARTUP_CYC > HALT_CYC) ? STARTUP_CYC : HALT_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] START_LD = CNT_W'(STARTUP_CYC - 1);
  localparam logic [CNT_W-1:0] HALT_LD  = CNT_W'(HALT_CYC - 1);

  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mode_ld;
  logic             resume_q, resume_d;
  logic             rstv_q, rstv_d;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    mode_ld  = 1'b0;
    resume_d = 1'b0;
    rstv_d   = 1'b0;
    case (st_q)
      ST_RUN: begin
        if (sleep_go) begin
          st_d    = ST_SLEEP;
          mode_ld = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (rst_wake) begin
          st_d   = ST_RUN;
          rstv_d = 1'b1;
        end else if (wake_hit) begin
          st_d  = need_start ? ST_START : ST_HALT;
          cnt_d = need_start ? START_LD : HALT_LD;
        end
      end
      ST_START: begin
        if (rst_wake) begin
          st_d   = ST_RUN;
          rstv_d = 1'b1;
        end else if (cnt_q == '0) begin
          st_d  = ST_HALT;
          cnt_d = HALT_LD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        if (rst_wake) begin
          st_d   = ST_RUN;
          rstv_d = 1'b1;
        end else if (cnt_q == '0) begin
          st_d     = ST_RUN;
          resume_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_RUN;
      cnt_q    <= '0;
      mode_q   <= MD_IDLE;
      resume_q <= 1'b0;
      rstv_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      resume_q <= resume_d;
      rstv_q   <= rstv_d;
      if (mode_ld) begin
        mode_q <= mode_in;
      end
    end
  end

  assign st      = st_q;
  assign resume  = resume_q;
  assign rst_vec = rstv_q;
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
  import slp_pkg::*;
#(
  parameter int STARTUP_CYC = 16,
  parameter int HALT_CYC    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [2:0]        cfg_mode,
  input  logic              t2_async,
  input  logic [1:0]        int_level,
  input  logic              sleep_req,
  input  logic [WAKE_N-1:0] wake_req,
  input  logic              rst_wake,
  output logic              clk_cpu_en,
  output logic              clk_flash_en,
  output logic              clk_io_en,
  output logic              clk_adc_en,
  output logic              clk_asy_en,
  output logic              osc_main_en,
  output logic              osc_tmr_en,
  output logic              core_halt,
  output logic              resume,
  output logic              rst_vec
);
  logic [1:0]        rst_sync;
  logic              rst_sync_n;
  clk_en_t           clk_sleep;
  clk_en_t           clk_out;
  logic [WAKE_N-1:0] wake_mask;
  logic              need_start;
  logic              idle_like;
  logic              wake_hit;
  logic [2:0]        mode_q;
  seq_st_e           st;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync[1];

  slp_mode_lut u_lut (
    .mode       (mode_q),
    .t2_async   (t2_async),
    .clk_sleep  (clk_sleep),
    .wake_mask  (wake_mask),
    .need_start (need_start),
    .idle_like  (idle_like)
  );

  slp_wake_filter #(.EXT_N(2)) u_filt (
    .wake_req  (wake_req),
    .wake_mask (wake_mask),
    .int_level (int_level),
    .idle_like (idle_like),
    .wake_hit  (wake_hit)
  );

  slp_seq #(
    .STARTUP_CYC (STARTUP_CYC),
    .HALT_CYC    (HALT_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sleep_go   (sleep_req & cfg_en),
    .mode_in    (cfg_mode),
    .wake_hit   (wake_hit),
    .need_start (need_start),
    .rst_wake   (rst_wake),
    .st         (st),
    .mode_q     (mode_q),
    .resume     (resume),
    .rst_vec    (rst_vec)
  );

  always_comb begin
    case (st)
      ST_SLEEP: clk_out = clk_sleep;
      ST_START: begin
        clk_out      = clk_sleep;
        clk_out.main = 1'b1;
      end
      default:  clk_out = CLK_ALL_ON;
    endcase
  end

  assign clk_cpu_en   = clk_out.cpu;
  assign clk_flash_en = clk_out.flash;
  assign clk_io_en    = clk_out.io;
  assign clk_adc_en   = clk_out.adc;
  assign clk_asy_en   = clk_out.asy;
  assign osc_main_en  = clk_out.main;
  assign osc_tmr_en   = clk_out.tosc;
  assign core_halt    = (st != ST_RUN);
endmodule

// File: rtl/slp_ctrl_chk.sv
module slp_ctrl_chk (
  input logic clk,
  input logic arst_n,
  input logic cfg_en,
  input logic sleep_req,
  input logic rst_wake,
  input logic clk_cpu_en,
  input logic clk_flash_en,
  input logic clk_io_en,
  input logic osc_main_en,
  input logic core_halt,
  input logic resume,
  input logic rst_vec
);
  p_ignored_strobe_r2: assert property (@(posedge clk) disable iff (!arst_n)
    (!core_halt && sleep_req && !cfg_en) |=> !core_halt);

  p_entry_r3: assert property (@(posedge clk) disable iff (!arst_n)
    (!core_halt && sleep_req && cfg_en) |=> (core_halt && !clk_cpu_en));

  p_cpu_flash_pair_r4: assert property (@(posedge clk) disable iff (!arst_n)
    !clk_cpu_en |-> (!clk_flash_en && core_halt));

  p_resume_single_r8: assert property (@(posedge clk) disable iff (!arst_n)
    resume |=> !resume);

  p_resume_edge_r8: assert property (@(posedge clk) disable iff (!arst_n)
    resume |-> (!core_halt && $past(core_halt)));

  p_halt_window_on_r8: assert property (@(posedge clk) disable iff (!arst_n)
    (core_halt && clk_cpu_en) |-> (clk_io_en && osc_main_en));

  p_restart_r9: assert property (@(posedge clk) disable iff (!arst_n)
    rst_vec |-> (!core_halt && !resume && $past(core_halt)));

  p_reset_ignored_run_r9: assert property (@(posedge clk) disable iff (!arst_n)
    (!core_halt && rst_wake) |=> !rst_vec);
endmodule

bind slp_ctrl slp_ctrl_chk u_chk (
  .clk          (clk),
  .arst_n       (rst_sync_n),
  .cfg_en       (cfg_en),
  .sleep_req    (sleep_req),
  .rst_wake     (rst_wake),
  .clk_cpu_en   (clk_cpu_en),
  .clk_flash_en (clk_flash_en),
  .clk_io_en    (clk_io_en),
  .osc_main_en  (osc_main_en),
  .core_halt    (core_halt),
  .resume       (resume),
  .rst_vec      (rst_vec)
);

// File: tb/tb_slp_ctrl.sv
module tb_slp_ctrl;
  localparam int SC = 6;
  localparam int HC = 4;

  logic       clk;
  logic       rst_n;
  logic       cfg_en;
  logic [2:0] cfg_mode;
  logic       t2_async;
  logic [1:0] int_level;
  logic       sleep_req;
  logic [8:0] wake_req;
  logic       rst_wake;
  logic       clk_cpu_en, clk_flash_en, clk_io_en, clk_adc_en, clk_asy_en;
  logic       osc_main_en, osc_tmr_en, core_halt, resume, rst_vec;
  int         checks;
  int         errors;

  slp_ctrl #(.STARTUP_CYC(SC), .HALT_CYC(HC)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mode(cfg_mode), .t2_async(t2_async),
    .int_level(int_level), .sleep_req(sleep_req), .wake_req(wake_req), .rst_wake(rst_wake),
    .clk_cpu_en(clk_cpu_en), .clk_flash_en(clk_flash_en), .clk_io_en(clk_io_en),
    .clk_adc_en(clk_adc_en), .clk_asy_en(clk_asy_en), .osc_main_en(osc_main_en),
    .osc_tmr_en(osc_tmr_en), .core_halt(core_halt), .resume(resume), .rst_vec(rst_vec)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [6:0] clks();
    return {clk_cpu_en, clk_flash_en, clk_io_en, clk_adc_en, clk_asy_en, osc_main_en, osc_tmr_en};
  endfunction

  function automatic logic [6:0] exp_clk(logic [2:0] m, logic a);
    case (m)
      3'b001:  return {5'b00011, 1'b1, a};
      3'b010:  return 7'b0;
      3'b011:  return {4'b0000, a, 1'b0, a};
      3'b110:  return 7'b0000010;
      3'b111:  return {4'b0000, a, 1'b1, a};
      default: return {5'b00111, 1'b1, a};
    endcase
  endfunction

  function automatic logic [8:0] exp_mask(logic [2:0] m, logic [1:0] lvl);
    logic [8:0] r;
    case (m)
      3'b001:         r = 9'h0FF;
      3'b010, 3'b110: r = 9'h08F;
      3'b011, 3'b111: r = 9'h09F;
      default:        r = 9'h1FF;
    endcase
    if (m != 3'b000 && m != 3'b100 && m != 3'b101) begin
      r[0] = r[0] & lvl[0];
      r[1] = r[1] & lvl[1];
    end
    return r;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic enter(input logic [2:0] m, input logic a);
    @(negedge clk);
    cfg_en = 1'b1; cfg_mode = m; t2_async = a; sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    chk(core_halt, "R3 halt after entry", core_halt, 1);
    chk(clks() == exp_clk(m, a), "R4 sleep enables", clks(), exp_clk(m, a));
  endtask

  // raise one wake bit for one edge; count edges until the core runs again
  task automatic wake_count(input int b, output int n);
    wake_req = 9'b0;
    wake_req[b] = 1'b1;
    n = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      n++;
      wake_req = 9'b0;
      if (core_halt && clk_cpu_en)
        chk(clks() == 7'h7F, "R8 clocks on in halt window", clks(), 7'h7F);
    end while (core_halt && n < 200);
  endtask

  task automatic t_mode(input logic [2:0] m, input logic a, input logic [1:0] lvl);
    logic [8:0] msk;
    int         n;
    int         first;
    int         expn;
    msk = exp_mask(m, lvl);
    int_level = lvl;
    enter(m, a);
    for (int b = 0; b < 9; b++) begin
      if (!msk[b]) begin
        wake_req = 9'b0;
        wake_req[b] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wake_req = 9'b0;
        chk(core_halt && clks() == exp_clk(m, a), "R5 R6 R7 masked source", {core_halt, clks()},
            {1'b1, exp_clk(m, a)});
      end
    end
    first = 0;
    for (int b = 8; b >= 0; b--) if (msk[b]) first = b;
    wake_count(first, n);
    expn = ((m == 3'b010) || (m == 3'b011)) ? SC + HC + 1 : HC + 1;
    chk(n == expn && resume, "R8 wake latency", n, expn);
    @(negedge clk);
    chk(!resume && !core_halt, "R8 resume single cycle", resume, 0);
  endtask

  task automatic t_reset();
    chk(clks() == 7'h7F && !core_halt && !resume && !rst_vec, "R1 reset state",
        {core_halt, resume, rst_vec, clks()}, 10'h07F);
  endtask

  task automatic t_disabled();
    @(negedge clk);
    cfg_en = 1'b0; cfg_mode = 3'b010; sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    chk(!core_halt && clks() == 7'h7F, "R2 strobe without enable", {core_halt, clks()}, 8'h7F);
  endtask

  task automatic t_rst_wake();
    @(negedge clk);
    rst_wake = 1'b1;
    @(negedge clk);
    rst_wake = 1'b0;
    chk(!rst_vec && !core_halt, "R9 no effect while running", rst_vec, 0);
    enter(3'b010, 1'b0);
    rst_wake = 1'b1;
    @(negedge clk);
    rst_wake = 1'b0;
    chk(!core_halt && rst_vec && !resume && clks() == 7'h7F, "R9 reset wake",
        {core_halt, rst_vec, resume}, 3'b010);
    @(negedge clk);
    chk(!rst_vec, "R9 restart pulse single", rst_vec, 0);
  endtask

  task automatic t_latched();
    int n;
    int_level = 2'b00;
    enter(3'b010, 1'b0);
    cfg_mode = 3'b000;
    wake_req = 9'h100;
    @(posedge clk);
    @(negedge clk);
    wake_req = 9'b0;
    chk(core_halt && clks() == 7'b0, "R10 mode held during sleep", {core_halt, clks()}, 8'h80);
    wake_count(7, n);
    chk(n == SC + HC + 1, "R10 latched mode timing", n, SC + HC + 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; cfg_en = 1'b0; cfg_mode = 3'b000; t2_async = 1'b0; int_level = 2'b00;
    sleep_req = 1'b0; wake_req = 9'b0; rst_wake = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_disabled();
    t_mode(3'b000, 1'b1, 2'b00);
    t_mode(3'b001, 1'b0, 2'b00);
    t_mode(3'b010, 1'b0, 2'b00);
    t_mode(3'b011, 1'b1, 2'b00);
    t_mode(3'b110, 1'b0, 2'b00);
    t_mode(3'b111, 1'b0, 2'b00);
    t_mode(3'b111, 1'b1, 2'b00);
    t_mode(3'b101, 1'b0, 2'b00);
    t_mode(3'b100, 1'b1, 2'b00);
    t_mode(3'b010, 1'b0, 2'b10);
    t_mode(3'b011, 1'b0, 2'b01);
    t_rst_wake();
    t_latched();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule